// File: doc/BRIEF.md
# Fetch-Block Branch Prediction Unit

This unit sits beside the instruction fetch path. Each cycle it receives the address of the current fetch, the aligned group of four 32-bit instruction words containing that address, and a small predecode code for every word. It returns, in the same cycle, the address the next fetch should use and a mask of the instruction slots that really belong to the executed path. It also reports whether a flow change was predicted and in which slot.

Conditional branches are predicted by a table of two-bit saturating counters. The table is addressed by low word-address bits, and resolved outcomes coming back from execution train it. Direct flow changes get their target from one displacement adder per slot, and all four adders work in parallel. Subroutine returns take the low address bits of their target from a small circular stack of return addresses. A redirect from the back end after a misprediction overrides the predicted address in the cycle it arrives.

Top module: `fetch_block_predictor`

## Requirements
- R1: After reset every counter holds the value 1. A conditional slot is predicted taken only when its counter is 2 or 3, so after reset every conditional branch is predicted not taken.
- R2: A resolution presented with `res_valid` in cycle t moves its counter one step up for taken or one step down for not taken, saturating at 3 and 0. Predictions first see the new value in cycle t+2.
- R3: The counter for a slot is selected by bits [IDX_W+1:2] of that slot's address, where IDX_W = log2(CTR_ENTRIES). Addresses that agree in those bits share one counter.
- R4: The predecode code of each slot is read from its bits [2:0]: 0 none, 1 conditional branch, 2 unconditional jump, 3 call, 4 return. Codes 5 to 7 mean none, and bits [4:3] are ignored.
- R5: The target of a jump, call or conditional branch in a slot is the slot address + 4 + 4 times the sign-extended value of instruction bits [20:0].
- R6: Jumps, calls and returns in a valid slot are always taken. The lowest valid taken slot alone sets `next_pc`, `pred_taken` and `pred_slot`. A call in a later slot has no effect on the return stack.
- R7: `slot_valid[i]` is 1 exactly when i >= `fetch_pc[3:2]`. Flow changes in slots below the entry point are ignored.
- R8: With no taken slot, `next_pc` is the block base (`fetch_pc` with bits [3:0] cleared) + 16, `pred_taken` is 0 and `pred_slot` is 0.
- R9: When a call is chosen, bits [RAS_W+1:2] of (call address + 4) are pushed. When a return is chosen, its target is {`fetch_pc`[ADDR_W-1:RAS_W+2], top entry, 2'b00} and the entry is popped.
- R10: The return stack is circular with RAS_DEPTH entries. A push beyond its depth overwrites the oldest entry, and a pop from an empty stack returns whatever entry the wrapped pointer reaches.
- R11: While `redir_valid` is 1, `next_pc` equals `redir_pc` and the return stack is left unchanged.
- R12: While `fetch_valid` is 0, the return stack is left unchanged.
- R13: After reset all return stack entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | The current block is a real fetch and may update the return stack |
| fetch_pc | input | ADDR_W | Address of the current fetch; bits [3:2] give the entry slot |
| fetch_instr | input | 128 | Four instruction words, slot 0 in bits [31:0] |
| fetch_predecode | input | 20 | Five predecode bits per slot, slot 0 in bits [4:0] |
| res_valid | input | 1 | A resolved conditional branch outcome is present |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| redir_valid | input | 1 | Misprediction redirect from the back end |
| redir_pc | input | ADDR_W | Corrected fetch address |
| next_pc | output | ADDR_W | Address for the next fetch |
| slot_valid | output | 4 | Per-slot valid mask of the current block |
| pred_taken | output | 1 | A flow change was predicted in this block |
| pred_slot | output | 2 | Slot of the predicted flow change |

## Verification
The bench builds the unit with a 64-entry counter table and a four-deep return stack, and keeps the 32-bit address width. The small table lets two branch addresses only 256 bytes apart alias onto one counter. The shallow stack lets five nested calls and six returns run the pointer through both overflow and underflow within a few dozen cycles. A behavioural model, built from integer arrays and modulo arithmetic, predicts every output in every cycle. It covers saturation at both ends, the two-cycle training delay, and the upper target bits taken from the fetch address.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int INSN_W = 32;
  localparam int PD_W   = 5;
  localparam int DISP_W = 21;

  typedef enum logic [2:0] {
    FK_NONE = 3'd0,
    FK_COND = 3'd1,
    FK_JUMP = 3'd2,
    FK_CALL = 3'd3,
    FK_RET  = 3'd4
  } flow_kind_e;

  // Maps the low three predecode bits to a flow kind; unknown codes are plain.
  function automatic flow_kind_e pd_kind(input logic [2:0] code);
    case (code)
      3'd1:    return FK_COND;
      3'd2:    return FK_JUMP;
      3'd3:    return FK_CALL;
      3'd4:    return FK_RET;
      default: return FK_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bpu_slot_target.sv
module bpu_slot_target
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] slot_pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target
);

  localparam int SX_W = ADDR_W - 2;

  logic [SX_W-1:0] disp_sx;

  assign disp_sx = {{(SX_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign target  = slot_pc + ADDR_W'(4) + {disp_sx, 2'b00};

endmodule

// File: rtl/bpu_ctr_table.sv
module bpu_ctr_table #(
  parameter int ENTRIES = 2048,
  parameter int PORTS   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PORTS-1:0][IDX_W-1:0] rd_idx,
  output logic [PORTS-1:0][1:0]       rd_ctr,
  input  logic                        upd_valid,
  input  logic [IDX_W-1:0]            upd_idx,
  input  logic                        upd_taken
);

  logic [1:0]       ctr_mem [ENTRIES];
  logic             pend_v_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             pend_tk_q;
  logic [1:0]       cur_ctr;
  logic [1:0]       new_ctr;

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd_ctr[p] = ctr_mem[rd_idx[p]];
  end

  // Next value of the counter addressed by the pending update.
  always_comb begin
    cur_ctr = ctr_mem[pend_idx_q];
    if (pend_tk_q) new_ctr = (cur_ctr == 2'b11) ? cur_ctr : cur_ctr + 2'b01;
    else           new_ctr = (cur_ctr == 2'b00) ? cur_ctr : cur_ctr - 2'b01;
  end

  // One-cycle staging of the resolution port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      pend_tk_q  <= 1'b0;
    end else begin
      pend_v_q <= upd_valid;
      if (upd_valid) begin
        pend_idx_q <= upd_idx;
        pend_tk_q  <= upd_taken;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ctr_mem[i] <= 2'b01;
    end else if (pend_v_q) begin
      ctr_mem[pend_idx_q] <= new_ctr;
    end
  end

  // R2: a taken outcome never lowers the counter, a not-taken one never raises it.
  assert_ctr_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && pend_tk_q) |=> (ctr_mem[$past(pend_idx_q)] >= $past(cur_ctr)));
  assert_ctr_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && !pend_tk_q) |=> (ctr_mem[$past(pend_idx_q)] <= $past(cur_ctr)));
  // R2: the top state is sticky under taken outcomes.
  assert_ctr_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && pend_tk_q && cur_ctr == 2'b11) |=> (ctr_mem[$past(pend_idx_q)] == 2'b11));

endmodule

// File: rtl/bpu_ras.sv
module bpu_ras #(
  parameter int DEPTH = 12,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    top_val = mem[ptr_dec];
    if (push)     ptr_d = ptr_inc;
    else if (pop) ptr_d = ptr_dec;
    else          ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (push) mem[ptr_q] <= push_val;
    end
  end

  // R9: a pushed link address is visible at the top in the next cycle.
  assert_push_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (top_val == $past(push_val)));
  // R9: the selector never asks for both operations at once.
  assert_single_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/fetch_block_predictor.sv
module fetch_block_predictor
  import bpu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CTR_ENTRIES = 2048,
  parameter int RAS_DEPTH   = 12,
  parameter int RAS_W       = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_valid,
  input  logic [ADDR_W-1:0]       fetch_pc,
  input  logic [SLOTS*INSN_W-1:0] fetch_instr,
  input  logic [SLOTS*PD_W-1:0]   fetch_predecode,
  input  logic                    res_valid,
  input  logic [ADDR_W-1:0]       res_pc,
  input  logic                    res_taken,
  input  logic                    redir_valid,
  input  logic [ADDR_W-1:0]       redir_pc,
  output logic [ADDR_W-1:0]       next_pc,
  output logic [SLOTS-1:0]        slot_valid,
  output logic                    pred_taken,
  output logic [SLOT_W-1:0]       pred_slot
);

  localparam int IDX_W  = $clog2(CTR_ENTRIES);
  localparam int HI_LSB = RAS_W + 2;
  localparam int INSN_HI_W = INSN_W - DISP_W;
  localparam int PD_HI_W   = PD_W - 3;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [ADDR_W-1:0]            blk_base;
  logic [SLOT_W-1:0]            entry_slot;
  logic [ADDR_W-1:0]            slot_pc    [SLOTS];
  logic [ADDR_W-1:0]            direct_tgt [SLOTS];
  flow_kind_e                   kind       [SLOTS];
  logic [SLOTS-1:0]             slot_take;
  logic [SLOTS-1:0][IDX_W-1:0]  rd_idx;
  logic [SLOTS-1:0][1:0]        rd_ctr;
  logic [SLOTS*INSN_HI_W-1:0]   insn_hi;
  logic [SLOTS*PD_HI_W-1:0]     pd_hi;
  logic [RAS_W-1:0]             ras_top;
  logic [ADDR_W-1:0]            ret_tgt;

  assign blk_base   = {fetch_pc[ADDR_W-1:4], 4'b0000};
  assign entry_slot = fetch_pc[3:2];
  assign ret_tgt    = {fetch_pc[ADDR_W-1:HI_LSB], ras_top, 2'b00};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] SIDX = SLOT_W'(s);

    assign slot_pc[s]    = blk_base + ADDR_W'(4 * s);
    assign kind[s]       = pd_kind(fetch_predecode[s*PD_W +: 3]);
    assign rd_idx[s]     = slot_pc[s][IDX_W+1:2];
    assign slot_valid[s] = (SIDX >= entry_slot);
    assign slot_take[s]  = slot_valid[s] &
                           ((kind[s] == FK_COND) ? rd_ctr[s][1] : (kind[s] != FK_NONE));
    assign insn_hi[s*INSN_HI_W +: INSN_HI_W] = fetch_instr[s*INSN_W+DISP_W +: INSN_HI_W];
    assign pd_hi[s*PD_HI_W +: PD_HI_W]       = fetch_predecode[s*PD_W+3 +: PD_HI_W];

    bpu_slot_target #(.ADDR_W(ADDR_W)) u_tgt (
      .slot_pc (slot_pc[s]),
      .disp    (fetch_instr[s*INSN_W +: DISP_W]),
      .target  (direct_tgt[s])
    );
  end

  bpu_ctr_table #(.ENTRIES(CTR_ENTRIES), .PORTS(SLOTS)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sync),
    .rd_idx    (rd_idx),
    .rd_ctr    (rd_ctr),
    .upd_valid (res_valid),
    .upd_idx   (res_pc[IDX_W+1:2]),
    .upd_taken (res_taken)
  );

  // Earliest taken slot wins.
  logic              sel_found;
  logic [SLOT_W-1:0] sel_slot;
  flow_kind_e        sel_kind;
  logic [ADDR_W-1:0] sel_tgt;
  logic [ADDR_W-1:0] link_addr;
  logic              commit;
  logic              ras_push;
  logic              ras_pop;

  always_comb begin
    sel_found = 1'b0;
    sel_slot  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slot_take[i] && !sel_found) begin
        sel_found = 1'b1;
        sel_slot  = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    sel_kind  = kind[sel_slot];
    sel_tgt   = (sel_kind == FK_RET) ? ret_tgt : direct_tgt[sel_slot];
    link_addr = slot_pc[sel_slot] + ADDR_W'(4);
    commit    = fetch_valid & ~redir_valid & sel_found;
    ras_push  = commit & (sel_kind == FK_CALL);
    ras_pop   = commit & (sel_kind == FK_RET);
    if (redir_valid)    next_pc = redir_pc;
    else if (sel_found) next_pc = sel_tgt;
    else                next_pc = blk_base + ADDR_W'(16);
  end

  assign pred_taken = sel_found;
  assign pred_slot  = sel_slot;

  bpu_ras #(.DEPTH(RAS_DEPTH), .W(RAS_W)) u_ras (
    .clk      (clk),
    .rst_n    (rst_sync),
    .push     (ras_push),
    .pop      (ras_pop),
    .push_val (link_addr[HI_LSB-1:2]),
    .top_val  (ras_top)
  );

  logic unused_bits;
  assign unused_bits = ^{insn_hi, pd_hi, rd_ctr, link_addr, fetch_pc[1:0],
                         res_pc[ADDR_W-1:IDX_W+2], res_pc[1:0]};

  // R6: no slot ahead of the chosen one is taken.
  assert_first_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    pred_taken |-> ((slot_take & ((SLOTS'(1) << pred_slot) - SLOTS'(1))) == '0));
  // R7: the chosen slot is inside the valid mask.
  assert_sel_valid_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    pred_taken |-> slot_valid[pred_slot]);
  // R11: a redirect freezes the return stack.
  assert_redir_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync)
    redir_valid |-> !(ras_push || ras_pop));
  // R12: an idle fetch freezes the return stack.
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_sync)
    !fetch_valid |-> !(ras_push || ras_pop));

endmodule

// File: tb/test_fetch_block_predictor.sv
`timescale 1ns/1ps
module test_fetch_block_predictor;

  localparam int AW = 32;
  localparam int CE = 64;
  localparam int RD = 4;
  localparam int RW = 11;

  logic          clk;
  logic          d_rst_n;
  logic          d_fv;
  logic [AW-1:0] d_pc;
  logic [127:0]  d_instr;
  logic [19:0]   d_pd;
  logic          d_rv;
  logic [AW-1:0] d_rpc;
  logic          d_rt;
  logic          d_dv;
  logic [AW-1:0] d_dpc;
  logic [AW-1:0] next_pc;
  logic [3:0]    slot_valid;
  logic          pred_taken;
  logic [1:0]    pred_slot;

  fetch_block_predictor #(.ADDR_W(AW), .CTR_ENTRIES(CE), .RAS_DEPTH(RD), .RAS_W(RW))
    i_fetch_block_predictor (
    .clk(clk), .rst_n(d_rst_n), .fetch_valid(d_fv), .fetch_pc(d_pc),
    .fetch_instr(d_instr), .fetch_predecode(d_pd),
    .res_valid(d_rv), .res_pc(d_rpc), .res_taken(d_rt),
    .redir_valid(d_dv), .redir_pc(d_dpc),
    .next_pc(next_pc), .slot_valid(slot_valid), .pred_taken(pred_taken), .pred_slot(pred_slot)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Stimulus shadows, copied onto the pins at each falling edge.
  logic          s_rst_n, s_fv, s_rv, s_rt, s_dv;
  logic [AW-1:0] s_pc, s_rpc, s_dpc;
  logic [4:0]    s_pd   [4];
  logic [20:0]   s_disp [4];

  // Behavioural reference state.
  int          mctr [CE];
  logic [RW-1:0] mras [RD];
  int          mptr;
  bit          pv;
  int          pidx;
  bit          ptk;

  int n_chk;
  int n_fail;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 4; i++) begin
      s_pd[i] = 5'd0;
      s_disp[i] = 21'd0;
    end
    s_fv = 1'b1; s_rv = 1'b0; s_rpc = '0; s_rt = 1'b0; s_dv = 1'b0; s_dpc = '0;
  endtask

  task automatic res(input logic [31:0] pc, input bit tk);
    s_rv = 1'b1; s_rpc = pc; s_rt = tk;
  endtask

  task automatic step(input string req);
    logic [31:0] base, tgt, exp_next;
    logic [3:0]  emask;
    bit          found;
    int          sel, selk, entry;
    @(negedge clk);
    d_rst_n = s_rst_n; d_fv = s_fv; d_pc = s_pc; d_rv = s_rv; d_rpc = s_rpc;
    d_rt = s_rt; d_dv = s_dv; d_dpc = s_dpc;
    for (int i = 0; i < 4; i++) begin
      d_instr[i*32 +: 32] = {11'h5A5, s_disp[i]};
      d_pd[i*5 +: 5] = s_pd[i];
    end
    #1;
    base = s_pc & 32'hFFFF_FFF0;
    entry = int'(s_pc[3:2]);
    found = 0; sel = 0; selk = 0; tgt = '0; emask = '0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] spc, t, dsx;
      int k;
      bit tk;
      spc = base + 32'(4 * i);
      k = int'(s_pd[i][2:0]);
      dsx = {{11{s_disp[i][20]}}, s_disp[i]};
      t = spc + 32'd4 + (dsx << 2);
      tk = 0;
      case (k)
        1: tk = (mctr[(spc >> 2) % CE] >= 2);
        2, 3: tk = 1;
        4: begin
          tk = 1;
          t = {s_pc[31:13], mras[(mptr + RD - 1) % RD], 2'b00};
        end
        default: tk = 0;
      endcase
      if (i >= entry) begin
        emask[i] = 1'b1;
        if (tk && !found) begin
          found = 1; sel = i; selk = k; tgt = t;
        end
      end
    end
    exp_next = s_dv ? s_dpc : (found ? tgt : base + 32'd16);
    check(req, "next_pc", next_pc, exp_next);
    check(req, "slot_valid", {28'd0, slot_valid}, {28'd0, emask});
    check(req, "pred_taken", {31'd0, pred_taken}, {31'd0, found});
    check(req, "pred_slot", {30'd0, pred_slot}, 32'(sel));
    @(posedge clk);
    if (pv) begin
      if (ptk) begin
        if (mctr[pidx] < 3) mctr[pidx]++;
      end else if (mctr[pidx] > 0) mctr[pidx]--;
    end
    pv = s_rv; pidx = int'((s_rpc >> 2) % CE); ptk = s_rt;
    if (s_fv && !s_dv && found) begin
      if (selk == 3) begin
        logic [31:0] link;
        link = base + 32'(4 * sel) + 32'd4;
        mras[mptr] = link[12:2];
        mptr = (mptr + 1) % RD;
      end else if (selk == 4) begin
        mptr = (mptr + RD - 1) % RD;
      end
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < CE; i++) mctr[i] = 1;
    for (int i = 0; i < RD; i++) mras[i] = '0;
    mptr = 0; pv = 0; pidx = 0; ptk = 0;

    // Reset state: weak not-taken counters, zeroed stack (R1, R13).
    s_rst_n = 1'b0; clr(); s_fv = 1'b0; s_pc = 32'h100;
    step("R1");
    s_pd[0] = 5'd1; s_disp[0] = 21'h30; step("R1");
    s_pd[0] = 5'd4; step("R13");
    s_rst_n = 1'b1; s_pd[0] = 5'd0;
    repeat (3) step("R13");
    s_fv = 1'b1; s_pc = 32'h0004_8100; s_pd[0] = 5'd4; s_fv = 1'b0; step("R13");

    // Sequential fall-through (R8) and mid-block entry (R7).
    clr(); s_pc = 32'h1000; step("R8");
    s_pc = 32'h1008; s_pd[0] = 5'd2; s_pd[1] = 5'd3; s_disp[1] = 21'h7; step("R7");
    clr(); s_pc = 32'h100C; step("R7");
    s_pd[3] = 5'd2; s_disp[3] = 21'd5; step("R7");

    // Displacement targets, positive and negative (R5).
    clr(); s_pc = 32'h2000; s_pd[2] = 5'd2; s_disp[2] = 21'h40; step("R5");
    s_pd[1] = 5'd2; s_disp[1] = 21'h1FFFFD; step("R5");

    // Earliest taken slot wins (R6).
    clr(); s_pc = 32'h2010; s_pd[1] = 5'd2; s_disp[1] = 21'd10; s_pd[3] = 5'd2; s_disp[3] = 21'd99; step("R6");
    clr(); s_pc = 32'h2020; s_pd[0] = 5'd1; s_disp[0] = 21'd7; s_pd[2] = 5'd2; s_disp[2] = 21'd8; step("R6");

    // Predecode decoding (R4).
    clr(); s_pc = 32'h2030; s_pd[0] = 5'd5; s_pd[1] = 5'd6; s_pd[2] = 5'd7; s_pd[3] = 5'b11000; step("R4");
    s_pd[1] = 5'b11010; s_disp[1] = 21'd3; step("R4");

    // Counter training, delay and saturation (R2).
    clr(); s_pc = 32'h3000; s_pd[0] = 5'd1; s_disp[0] = 21'h20;
    repeat (4) begin res(32'h3000, 1'b1); step("R2"); end
    s_rv = 1'b0; repeat (2) step("R2");
    res(32'h3000, 1'b0); step("R2");
    s_rv = 1'b0; repeat (2) step("R2");
    repeat (2) begin res(32'h3000, 1'b0); step("R2"); end
    s_rv = 1'b0; repeat (2) step("R2");
    repeat (3) begin res(32'h3000, 1'b0); step("R2"); end
    res(32'h3000, 1'b1); step("R2");
    s_rv = 1'b0; repeat (2) step("R2");

    // Index aliasing (R3).
    repeat (2) begin res(32'h3000, 1'b1); step("R3"); end
    s_rv = 1'b0; repeat (2) step("R3");
    clr(); s_pc = 32'h3100; s_pd[0] = 5'd1; s_disp[0] = 21'h11; step("R3");
    clr(); s_pc = 32'h3000; s_pd[1] = 5'd1; s_disp[1] = 21'h12; step("R3");

    // Call and return (R9).
    clr(); s_pc = 32'h4004; s_pd[1] = 5'd3; s_disp[1] = 21'h100; step("R9");
    clr(); s_pc = 32'h4240; s_pd[0] = 5'd4; step("R9");
    clr(); s_pc = 32'h4000; s_pd[0] = 5'd3; s_disp[0] = 21'h80; step("R9");
    clr(); s_pc = 32'h0004_6240; s_pd[2] = 5'd4; step("R9");

    // Overflow and underflow of the circular stack (R10).
    for (int n = 0; n < 5; n++) begin
      clr(); s_pc = 32'h5000 + 32'(n * 16); s_pd[n % 4] = 5'd3; s_disp[n % 4] = 21'h40;
      step("R10");
    end
    for (int n = 0; n < 6; n++) begin
      clr(); s_pc = 32'h6000; s_pd[0] = 5'd4; step("R10");
    end

    // Redirect overrides and freezes the stack (R11).
    clr(); s_pc = 32'h7000; s_pd[0] = 5'd3; s_disp[0] = 21'h9; s_dv = 1'b1; s_dpc = 32'h9ABC; step("R11");
    s_dv = 1'b0; s_pd[0] = 5'd4; step("R11");
    s_dv = 1'b1; s_dpc = 32'h1234; step("R11");
    s_dv = 1'b0; step("R11");

    // Idle fetch leaves the stack alone (R12).
    clr(); s_pc = 32'h7040; s_fv = 1'b0; s_pd[0] = 5'd3; s_disp[0] = 21'h3; step("R12");
    s_fv = 1'b1; s_pd[0] = 5'd4; step("R12");

    // A call behind an earlier jump does not push (R6).
    clr(); s_pc = 32'h7100; s_pd[0] = 5'd2; s_disp[0] = 21'h4; s_pd[1] = 5'd3; s_disp[1] = 21'h5; step("R6");
    s_pd[0] = 5'd4; s_pd[1] = 5'd0; step("R6");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule